// File: doc/BRIEF.md
# Unrolled Normalized Restoring Divider

This block divides a 16-bit unsigned dividend by an 8-bit unsigned divisor. It returns an 8-bit quotient, an 8-bit remainder and two error flags. A front-end normalizer finds the leading zeros of the divisor. It shifts the divisor and the dividend left by that amount, so the divisor reaching the array always has its top bit set. The array is a fixed chain of eight identical subtract-and-select slices, one for each quotient bit, from the most significant down. Each slice forms a 9-bit partial remainder. It compares that value against the normalized divisor, and its no-borrow carry becomes both the quotient bit and the select of its keep-or-subtract mux. At the output, the final remainder is shifted back right by the recorded amount.

A parameter places a register after every slice. With it set, the block accepts one operand pair per clock and returns each result exactly eight clocks later, in order. With it cleared, the whole array is combinational and the result appears in the same cycle. Latency never depends on operand values. A zero divisor, or a quotient too large for 8 bits, is flagged rather than computed.

Top module: `udiv_unrolled`

## Requirements
- R1: For divisor d != 0 and dividend bits 15:8 less than d, quot_o equals floor(dividend / d).
- R2: Under the same conditions, rem_o equals dividend mod d, which is always less than d.
- R3: A divisor of 0 sets div_zero_o=1 and ovf_o=0, and drives quot_o=8'hFF and rem_o=8'hFF.
- R4: A nonzero divisor with dividend bits 15:8 >= divisor sets ovf_o=1 and div_zero_o=0, and drives quot_o=8'hFF and rem_o=8'hFF.
- R5: With PIPE_EN=1, an operand pair accepted at one rising edge shows its result with out_valid_o=1 after the eighth rising edge, counting that edge as the first. Back-to-back pairs give back-to-back results in order. With PIPE_EN=0, the result appears combinationally in the same cycle.
- R6: in_ready_o is 0 while rst_ni is low and 1 otherwise. An operand pair is taken in every cycle where in_valid_i and in_ready_o are both 1.
- R7: While rst_ni is low, out_valid_o is 0, and it stays 0 until the first accepted pair reaches the output.
- R8: A cycle with in_valid_i=0 produces no result, whatever values sit on dividend_i and divisor_i. The corresponding output cycle has out_valid_o=0.
- R9: Results are correct for every divisor leading-zero count, including divisor 1, divisor 255, divisor 128, dividend 0 and the largest dividend that does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is present |
| in_ready_o | output | 1 | Block can take an operand pair |
| dividend_i | input | 16 | Unsigned dividend |
| divisor_i | input | 8 | Unsigned divisor |
| out_valid_o | output | 1 | Result fields are valid |
| quot_o | output | 8 | Quotient, all ones on an error |
| rem_o | output | 8 | Remainder, all ones on an error |
| div_zero_o | output | 1 | Divisor was zero |
| ovf_o | output | 1 | Quotient would not fit in 8 bits |

## Verification
A slice that picks the wrong mux input or drops the shifted-out ninth bit corrupts one quotient bit and every remainder after it. This shows at the output as a quotient-times-divisor-plus-remainder mismatch on the very result that passed through it. A wrong normalization shift count only shows for divisors with that many leading zeros, so the stimulus sweeps all eight counts. A stuck valid bit or a misaligned pipeline stage appears as a result arriving one cycle early or late, or out of order, and the scoreboard notices this on the first affected item.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  parameter int unsigned DIV_W = 8;
  localparam int unsigned NUM_W = 2 * DIV_W;
  localparam int unsigned SH_W  = $clog2(DIV_W);

  // State carried between slices
  typedef struct packed {
    logic             vld;
    logic             dz;
    logic             ovf;
    logic [SH_W-1:0]  sh;
    logic [DIV_W-1:0] dn;   // normalized divisor
    logic [DIV_W-1:0] rem;  // partial remainder
    logic [DIV_W-1:0] lo;   // dividend bits still to be brought down
    logic [DIV_W-1:0] quo;
  } slice_t;
endpackage

// File: rtl/udiv_norm.sv
module udiv_norm
  import udiv_pkg::*;
(
  input  logic             vld_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DIV_W-1:0] divisor_i,
  output slice_t           slice_o
);
  logic [SH_W-1:0]  sh;
  logic [NUM_W-1:0] num_sh;

  // leading-zero count; highest set bit wins
  always_comb begin
    sh = '0;
    for (int i = 0; i < DIV_W; i++)
      if (divisor_i[i]) sh = SH_W'(DIV_W - 1 - i);
  end

  assign num_sh = dividend_i << sh;

  always_comb begin
    slice_o     = '0;
    slice_o.vld = vld_i;
    slice_o.dz  = (divisor_i == '0);
    slice_o.ovf = (divisor_i != '0) && (dividend_i[NUM_W-1:DIV_W] >= divisor_i);
    slice_o.sh  = sh;
    slice_o.dn  = divisor_i << sh;
    slice_o.rem = num_sh[NUM_W-1:DIV_W];
    slice_o.lo  = num_sh[DIV_W-1:0];
  end
endmodule

// File: rtl/udiv_stage.sv
module udiv_stage
  import udiv_pkg::*;
(
  input  slice_t slice_i,
  output slice_t slice_o
);
  logic [DIV_W:0] part;
  logic [DIV_W:0] diff;
  logic           brw;
  logic           take;

  // 9-bit partial remainder: shifted-out bit forces a subtract
  assign part        = {slice_i.rem, slice_i.lo[DIV_W-1]};
  assign {brw, diff} = {1'b0, part} - {2'b00, slice_i.dn};
  assign take        = ~brw;

  always_comb begin
    slice_o     = slice_i;
    slice_o.rem = take ? diff[DIV_W-1:0] : part[DIV_W-1:0];
    slice_o.lo  = {slice_i.lo[DIV_W-2:0], 1'b0};
    slice_o.quo = {slice_i.quo[DIV_W-2:0], take};
  end
endmodule

// File: rtl/udiv_unrolled.sv
module udiv_unrolled
  import udiv_pkg::*;
#(
  parameter bit PIPE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             out_valid_o,
  output logic [DIV_W-1:0] quot_o,
  output logic [DIV_W-1:0] rem_o,
  output logic             div_zero_o,
  output logic             ovf_o
);
  slice_t pipe  [0:DIV_W];
  slice_t st_out[0:DIV_W-1];
  slice_t last;
  logic   err;
  logic   unused_w;

  assign in_ready_o = rst_ni;

  udiv_norm norm_i (
    .vld_i      (in_valid_i & in_ready_o),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .slice_o    (pipe[0])
  );

  for (genvar g = 0; g < DIV_W; g++) begin : g_stage
    udiv_stage stage_i (
      .slice_i (pipe[g]),
      .slice_o (st_out[g])
    );
    if (PIPE_EN) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[g+1] <= '0;
        else         pipe[g+1] <= st_out[g];
      end
    end else begin : g_comb
      assign pipe[g+1] = st_out[g];
    end
  end

  assign last        = pipe[DIV_W];
  assign err         = last.dz | last.ovf;
  assign out_valid_o = last.vld;
  assign div_zero_o  = last.dz;
  assign ovf_o       = last.ovf;
  assign quot_o      = err ? '1 : last.quo;
  assign rem_o       = err ? '1 : (last.rem >> last.sh);
  assign unused_w    = ^{last.lo, last.dn};
endmodule

// File: rtl/udiv_unrolled_chk.sv
module udiv_unrolled_chk
  import udiv_pkg::*;
#(
  parameter bit PIPE_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [NUM_W-1:0] dividend_i,
  input logic [DIV_W-1:0] divisor_i,
  input logic             out_valid_o,
  input logic [DIV_W-1:0] quot_o,
  input logic [DIV_W-1:0] rem_o,
  input logic             div_zero_o,
  input logic             ovf_o
);
  localparam int unsigned LAT = PIPE_EN ? DIV_W : 0;

  logic             v_d [0:LAT];
  logic [NUM_W-1:0] n_d [0:LAT];
  logic [DIV_W-1:0] d_d [0:LAT];

  assign v_d[0] = in_valid_i & in_ready_o;
  assign n_d[0] = dividend_i;
  assign d_d[0] = divisor_i;

  for (genvar i = 1; i <= LAT; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_d[i] <= 1'b0;
        n_d[i] <= '0;
        d_d[i] <= '0;
      end else begin
        v_d[i] <= v_d[i-1];
        n_d[i] <= n_d[i-1];
        d_d[i] <= d_d[i-1];
      end
    end
  end

  logic [DIV_W-1:0] d_o;
  logic [NUM_W-1:0] n_o;
  logic             good;
  assign d_o  = d_d[LAT];
  assign n_o  = n_d[LAT];
  assign good = out_valid_o && !div_zero_o && !ovf_o;

  // R5 R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v_d[LAT]);

  // R1
  quot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |-> (32'(quot_o) * 32'(d_o) + 32'(rem_o) == 32'(n_o)));

  // R2
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |-> (rem_o < d_o));

  // R3
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && d_o == '0) |-> (div_zero_o && !ovf_o && quot_o == '1 && rem_o == '1));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && d_o != '0 && n_o[NUM_W-1:DIV_W] >= d_o) |->
      (ovf_o && !div_zero_o && quot_o == '1 && rem_o == '1));

  // R6
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o);
endmodule

bind udiv_unrolled udiv_unrolled_chk #(.PIPE_EN(PIPE_EN)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .out_valid_o (out_valid_o),
  .quot_o      (quot_o),
  .rem_o       (rem_o),
  .div_zero_o  (div_zero_o),
  .ovf_o       (ovf_o)
);

// File: tb/udiv_unrolled_tb_top.sv
module udiv_unrolled_tb_top;
  import udiv_pkg::*;
  localparam bit PIPE_EN = 1'b1;
  localparam int LAT_EXP = PIPE_EN ? DIV_W : 0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [NUM_W-1:0] dividend = '0;
  logic [DIV_W-1:0] divisor = '0;
  logic             out_valid;
  logic [DIV_W-1:0] quot, rem;
  logic             dz, ovf;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;

  typedef struct {
    int n; int d; int q; int r; bit dz; bit ovf; int cyc;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udiv_unrolled #(.PIPE_EN(PIPE_EN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .dividend_i(dividend), .divisor_i(divisor), .out_valid_o(out_valid),
    .quot_o(quot), .rem_o(rem), .div_zero_o(dz), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic send(input int n, input int d);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1;
    dividend = NUM_W'(n);
    divisor  = DIV_W'(d);
    e.n = n; e.d = d; e.cyc = cyc;
    e.dz = (d == 0);
    e.ovf = (d != 0) && ((n >> DIV_W) >= d);
    if (e.dz || e.ovf) begin
      e.q = (1 << DIV_W) - 1; e.r = (1 << DIV_W) - 1;
    end else begin
      e.q = n / d; e.r = n % d;
    end
    sb.push_back(e);
    sent++;
  endtask

  // bubble with garbage operands (R8)
  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
    dividend = NUM_W'($urandom);
    divisor  = DIV_W'($urandom);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        string tq, tr;
        e = sb.pop_front();
        got++;
        tq = e.dz ? "R3 quot" : e.ovf ? "R4 quot" : "R1 quot";
        tr = e.dz ? "R3 rem"  : e.ovf ? "R4 rem"  : "R2 rem";
        check(int'(quot) == e.q, tq, int'(quot), e.q);
        check(int'(rem) == e.r, tr, int'(rem), e.r);
        check(dz == e.dz, "R3 div_zero flag", int'(dz), int'(e.dz));
        check(ovf == e.ovf, "R4 overflow flag", int'(ovf), int'(e.ovf));
        check(cyc - e.cyc == LAT_EXP, "R5 latency", cyc - e.cyc, LAT_EXP);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 R6: reset state
    check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b0, "R6 ready in reset", int'(in_ready), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R6 ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 out_valid idle", int'(out_valid), 0);

    // R9 corner cases
    send(0, 1);
    send(255, 1);
    send(256, 1);        // R4 overflow at divisor 1
    send(16'hFEFF, 255);
    send(16'hFFFF, 255); // R4
    send(0, 255);
    send(1234, 0);       // R3
    send(0, 0);          // R3
    send(16'h7FFF, 128);
    send(16'h7F00, 127); // R4 boundary equal
    send(16'h7EFF, 127);
    for (int k = 0; k < DIV_W; k++) send((1 << (DIV_W + k)) - 1, 1 << k);
    for (int k = 1; k < DIV_W; k++) send(((1 << k) - 1) * 256 + 255, 1 << k);
    idle();

    // back-to-back random, mostly in range (R1 R2 R5)
    for (int k = 0; k < 200; k++) begin
      int d, n;
      d = $urandom_range(1, 255);
      if ($urandom_range(0, 9) < 8) n = $urandom_range(0, d - 1) * 256 + $urandom_range(0, 255);
      else n = $urandom_range(0, 65535);
      if ($urandom_range(0, 19) == 0) d = 0;
      send(n, d);
    end

    // random with bubbles (R8)
    for (int k = 0; k < 150; k++) begin
      if ($urandom_range(0, 2) == 0) idle();
      else begin
        int d;
        d = $urandom_range(1, 255);
        send($urandom_range(0, d - 1) * 256 + $urandom_range(0, 255), d);
      end
    end
    idle();
    repeat (DIV_W + 4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R5 all results returned", sb.size(), 0);
    check(got == sent, "R8 result count", got, sent);
    check(out_valid == 1'b0, "R8 quiet after bubbles", int'(out_valid), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule